// File: doc/BRIEF.md
# Serial Converter Control Sequencer

This block is the master side of a four-wire serial link to an external analog-to-digital converter. It needs no processor. It waits out the converter's power-up time and then brings the converter's serial port back into step. Next it starts an offset self-calibration and waits for it to finish. It then writes the gain register and reads it back to check the value. After that it loops on single conversions and hands each 24-bit result word to the surrounding logic with a one-cycle valid strobe.

The serial clock is made from the system clock by a divider. The divider is computed from two parameters, the system clock frequency and the highest serial clock rate allowed (2 MHz by default), so the serial clock never runs faster than that limit. The block understands one status bit, the done flag. A done flag that never appears stops the sequence and raises an error output. A wrong gain read-back raises a mismatch output.

Top module: `adc_sequencer`

## Requirements
- R1: While reset is asserted and for POR_CYCLES cycles after it is released, chip select stays high (inactive), and the serial clock and data out stay low. The first chip-select fall comes exactly POR_CYCLES+1 clock cycles after reset is released. All result and flag outputs reset to 0.
- R2: The first frame is a resynchronising preamble. It holds chip select low without a break for SYNC_FILL_BYTES bytes of 0xFF followed by one byte of 0xFE (16 bytes at the default).
- R3: Each byte is shifted most significant bit first with eight serial clock pulses. Data out changes only while the serial clock is low and holds steady while it is high. Data out is low whenever chip select is high.
- R4: Every high phase of the serial clock lasts exactly HALF_DIV system cycles, and every low phase lasts at least HALF_DIV. HALF_DIV is ceil(SYS_CLK_HZ / (2*SCLK_MAX_HZ)).
- R5: The calibration frame is the four bytes 0x84, 0x00, 0x00, 0x01, sent under one chip-select frame.
- R6: A poll frame is 0x94 followed by three received bytes. Polling repeats until bit 3 of the last received byte is 1. All other received bits are ignored. Received data is sampled in the last system cycle of each serial-clock high phase.
- R7: After the calibration completes, the gain frame 0x82, 0x80, 0x00, 0x00 is sent, then a read-back frame 0x92 with three received bytes. gainMismatch goes to 1, and stays there, exactly when the read-back word differs from 0x800000.
- R8: Each conversion is the one-byte frame 0xC0, then polling as in R6, then the frame 0x96 with three received bytes. The 24-bit word received there, with the first bit received as bit 23, appears on resultData with resultValid high for one cycle. The cycle then repeats.
- R9: If POLL_LIMIT poll frames in a row come back without the done flag, pollTimeout goes to 1 and stays there. No further frame starts and no result is produced until reset.
- R10: Between two frames, chip select stays high for at least HALF_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adcCsN | output | 1 | Chip select to the converter, active low |
| adcSclk | output | 1 | Serial clock to the converter, idles low |
| adcDout | output | 1 | Serial data to the converter |
| adcDin | input | 1 | Serial data from the converter |
| resultData | output | 24 | Latest conversion word |
| resultValid | output | 1 | One-cycle strobe when resultData is updated |
| gainMismatch | output | 1 | Gain read-back differed from the written value |
| pollTimeout | output | 1 | Done flag not seen within POLL_LIMIT polls |

## Verification
The first chip-select fall is due exactly POR_CYCLES+1 cycles after reset is released. After that, every serial clock high phase lasts HALF_DIV cycles. The converter model drives each response bit on the system-clock falling edge that follows a serial-clock fall, which leaves a full high phase before the sequencer samples it. A conversion word shows up on resultValid in the cycle after the last bit of its read frame. The bench samples every output on system-clock falling edges and records whole frames as they end. It then compares the recorded frame sequence with a list it builds from the model's done-flag schedule, and it waits for results by polling with fixed cycle limits, never by assuming a count of cycles for a whole frame.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam logic [7:0] CMD_CFG_WR  = 8'h84;
  localparam logic [7:0] CMD_CFG_RD  = 8'h94;
  localparam logic [7:0] CMD_GAIN_WR = 8'h82;
  localparam logic [7:0] CMD_GAIN_RD = 8'h92;
  localparam logic [7:0] CMD_CONV    = 8'hC0;
  localparam logic [7:0] CMD_DATA_RD = 8'h96;
  localparam logic [7:0] SYNC_FILL   = 8'hFF;
  localparam logic [7:0] SYNC_LAST   = 8'hFE;

  localparam logic [23:0] CAL_WORD  = 24'h000001;
  localparam logic [23:0] GAIN_WORD = 24'h800000;
  localparam int          DONE_BIT  = 3;

  typedef enum logic [3:0] {
    ST_POR, ST_SYNC, ST_CAL_WR, ST_CAL_POLL, ST_GAIN_WR, ST_GAIN_RD,
    ST_CONV_CMD, ST_CONV_POLL, ST_CONV_RD, ST_HALT
  } seqStep_t;

  // strobes from the control to the shifter
  typedef struct packed {
    logic       selActive;
    logic       xferStart;
    logic [7:0] xferByte;
  } shiftCtl_t;

endpackage

// File: rtl/adc_seq_shift.sv
module adc_seq_shift
  import adc_seq_pkg::*;
#(
  parameter int HALF_DIV = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  shiftCtl_t  ctl,
  input  logic       serIn,
  output logic       serClk,
  output logic       serOut,
  output logic       selN,
  output logic       byteDone,
  output logic [7:0] rxByte
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             busy;
  logic             phaseHigh;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [7:0]       txReg;
  logic [7:0]       rxReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      phaseHigh <= 1'b0;
      divCnt    <= '0;
      bitCnt    <= '0;
      txReg     <= '0;
      rxReg     <= '0;
      byteDone  <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (!busy) begin
        if (ctl.xferStart) begin
          busy      <= 1'b1;
          phaseHigh <= 1'b0;
          divCnt    <= '0;
          bitCnt    <= '0;
          txReg     <= ctl.xferByte;
        end
      end else if (divCnt == DIV_LAST) begin
        divCnt <= '0;
        if (!phaseHigh) begin
          phaseHigh <= 1'b1;
        end else begin
          // last cycle of the high phase: sample, then fall
          phaseHigh <= 1'b0;
          rxReg     <= {rxReg[6:0], serIn};
          txReg     <= {txReg[6:0], 1'b0};
          if (bitCnt == 3'd7) begin
            busy     <= 1'b0;
            byteDone <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 3'd1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign serClk = phaseHigh;
  assign serOut = busy & txReg[7];
  assign selN   = ~ctl.selActive;
  assign rxByte = rxReg;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int HALF_DIV        = 13,
  parameter int POR_CYCLES      = 27_750_000,
  parameter int POLL_LIMIT      = 65_535,
  parameter int SYNC_FILL_BYTES = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteDone,
  input  logic [7:0]  rxByte,
  output shiftCtl_t   ctl,
  output logic [23:0] resultData,
  output logic        resultValid,
  output logic        gainMismatch,
  output logic        pollTimeout
);

  localparam int IDX_MAX = (SYNC_FILL_BYTES > 3) ? SYNC_FILL_BYTES : 3;
  localparam int IDX_W   = $clog2(IDX_MAX + 1);
  localparam int POR_W   = $clog2(POR_CYCLES + 1);
  localparam int POLL_W  = $clog2(POLL_LIMIT + 1);
  localparam int GAP_W   = $clog2(HALF_DIV + 1);

  seqStep_t          step;
  logic [POR_W-1:0]  porCnt;
  logic [IDX_W-1:0]  byteIdx;
  logic [POLL_W-1:0] pollCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [15:0]       rxWord;
  logic              waitDone;
  logic              selActive;

  logic [IDX_W-1:0]  lastIdx;
  logic [7:0]        txByte;
  logic              isRead;
  logic              issue;
  logic              frameEnd;
  logic [23:0]       fullWord;

  function automatic logic [7:0] pickByte(input logic [7:0] head,
                                          input logic [23:0] word,
                                          input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(0): pickByte = head;
      IDX_W'(1): pickByte = word[23:16];
      IDX_W'(2): pickByte = word[15:8];
      default:   pickByte = word[7:0];
    endcase
  endfunction

  always_comb begin
    lastIdx = IDX_W'(3);
    txByte  = 8'h00;
    case (step)
      ST_SYNC: begin
        lastIdx = IDX_W'(SYNC_FILL_BYTES);
        txByte  = (byteIdx == IDX_W'(SYNC_FILL_BYTES)) ? SYNC_LAST : SYNC_FILL;
      end
      ST_CAL_WR:    txByte = pickByte(CMD_CFG_WR, CAL_WORD, byteIdx);
      ST_GAIN_WR:   txByte = pickByte(CMD_GAIN_WR, GAIN_WORD, byteIdx);
      ST_CAL_POLL,
      ST_CONV_POLL: txByte = pickByte(CMD_CFG_RD, 24'h0, byteIdx);
      ST_GAIN_RD:   txByte = pickByte(CMD_GAIN_RD, 24'h0, byteIdx);
      ST_CONV_RD:   txByte = pickByte(CMD_DATA_RD, 24'h0, byteIdx);
      ST_CONV_CMD: begin
        lastIdx = IDX_W'(0);
        txByte  = CMD_CONV;
      end
      default: ;
    endcase
  end

  assign isRead   = step inside {ST_CAL_POLL, ST_GAIN_RD, ST_CONV_POLL, ST_CONV_RD};
  assign issue    = !(step inside {ST_POR, ST_HALT}) && !waitDone && (gapCnt == '0);
  assign frameEnd = byteDone && (byteIdx == lastIdx);
  assign fullWord = {rxWord, rxByte};

  assign ctl.selActive = selActive;
  assign ctl.xferStart = issue;
  assign ctl.xferByte  = txByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step         <= ST_POR;
      porCnt       <= '0;
      byteIdx      <= '0;
      pollCnt      <= '0;
      gapCnt       <= '0;
      rxWord       <= '0;
      waitDone     <= 1'b0;
      selActive    <= 1'b0;
      resultData   <= '0;
      resultValid  <= 1'b0;
      gainMismatch <= 1'b0;
      pollTimeout  <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (step == ST_POR) begin
        if (porCnt == POR_W'(POR_CYCLES - 1)) step <= ST_SYNC;
        else porCnt <= porCnt + 1'b1;
      end
      if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
      if (issue) begin
        waitDone  <= 1'b1;
        selActive <= 1'b1;
      end
      if (byteDone) begin
        waitDone <= 1'b0;
        if (isRead) rxWord <= fullWord[15:0];
        if (!frameEnd) begin
          byteIdx <= byteIdx + 1'b1;
        end else begin
          byteIdx   <= '0;
          selActive <= 1'b0;
          gapCnt    <= GAP_W'(HALF_DIV);
          case (step)
            ST_SYNC:   step <= ST_CAL_WR;
            ST_CAL_WR: begin
              step    <= ST_CAL_POLL;
              pollCnt <= '0;
            end
            ST_CAL_POLL, ST_CONV_POLL: begin
              if (fullWord[DONE_BIT]) begin
                step <= (step == ST_CAL_POLL) ? ST_GAIN_WR : ST_CONV_RD;
              end else if (pollCnt == POLL_W'(POLL_LIMIT - 1)) begin
                step        <= ST_HALT;
                pollTimeout <= 1'b1;
              end else begin
                pollCnt <= pollCnt + 1'b1;
              end
            end
            ST_GAIN_WR: step <= ST_GAIN_RD;
            ST_GAIN_RD: begin
              if (fullWord != GAIN_WORD) gainMismatch <= 1'b1;
              step <= ST_CONV_CMD;
            end
            ST_CONV_CMD: begin
              step    <= ST_CONV_POLL;
              pollCnt <= '0;
            end
            ST_CONV_RD: begin
              resultData  <= fullWord;
              resultValid <= 1'b1;
              step        <= ST_CONV_CMD;
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
  import adc_seq_pkg::*;
#(
  parameter int SYS_CLK_HZ      = 50_000_000,
  parameter int SCLK_MAX_HZ     = 2_000_000,
  parameter int POR_CYCLES      = 27_750_000,
  parameter int POLL_LIMIT      = 65_535,
  parameter int SYNC_FILL_BYTES = 15
) (
  input  logic        clk,
  input  logic        rstN,
  output logic        adcCsN,
  output logic        adcSclk,
  output logic        adcDout,
  input  logic        adcDin,
  output logic [23:0] resultData,
  output logic        resultValid,
  output logic        gainMismatch,
  output logic        pollTimeout
);

  localparam int HALF_DIV = (SYS_CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);

  shiftCtl_t  ctl;
  logic       byteDone;
  logic [7:0] rxByte;

  adc_seq_ctrl #(
    .HALF_DIV       (HALF_DIV),
    .POR_CYCLES     (POR_CYCLES),
    .POLL_LIMIT     (POLL_LIMIT),
    .SYNC_FILL_BYTES(SYNC_FILL_BYTES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .byteDone    (byteDone),
    .rxByte      (rxByte),
    .ctl         (ctl),
    .resultData  (resultData),
    .resultValid (resultValid),
    .gainMismatch(gainMismatch),
    .pollTimeout (pollTimeout)
  );

  adc_seq_shift #(
    .HALF_DIV(HALF_DIV)
  ) u_shift (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .serIn   (adcDin),
    .serClk  (adcSclk),
    .serOut  (adcDout),
    .selN    (adcCsN),
    .byteDone(byteDone),
    .rxByte  (rxByte)
  );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int HALF_DIV   = 13,
  parameter int POR_CYCLES = 27_750_000
) (
  input logic clk,
  input logic rstN,
  input logic adcCsN,
  input logic adcSclk,
  input logic adcDout,
  input logic resultValid,
  input logic gainMismatch,
  input logic pollTimeout
);

  logic [31:0] sinceRst;
  logic        lastSclk;
  logic        lastCs;
  logic [15:0] sclkRun;
  logic [15:0] csRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      lastSclk <= 1'b0;
      lastCs   <= 1'b1;
      sclkRun  <= 16'd1;
      csRun    <= 16'd1;
    end else begin
      if (sinceRst < 32'(POR_CYCLES)) sinceRst <= sinceRst + 32'd1;
      lastSclk <= adcSclk;
      lastCs   <= adcCsN;
      if (adcSclk != lastSclk) sclkRun <= 16'd1;
      else if (sclkRun != 16'hFFFF) sclkRun <= sclkRun + 16'd1;
      if (adcCsN != lastCs) csRun <= 16'd1;
      else if (csRun != 16'hFFFF) csRun <= csRun + 16'd1;
    end
  end

  // R1
  por_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < 32'(POR_CYCLES)) |-> (adcCsN && !adcSclk && !adcDout));

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adcSclk && lastSclk) |-> $stable(adcDout));

  // R3
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcCsN |-> (!adcSclk && !adcDout));

  // R4
  sclk_high_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((adcSclk != lastSclk) && lastSclk) |-> (sclkRun == 16'(HALF_DIV)));

  // R4
  sclk_low_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((adcSclk != lastSclk) && !lastSclk) |-> (sclkRun >= 16'(HALF_DIV)));

  // R10
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!adcCsN && lastCs) |-> (csRun >= 16'(HALF_DIV)));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R7
  mismatch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    gainMismatch |=> gainMismatch);

  // R9
  timeout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollTimeout |=> (pollTimeout && adcCsN && !resultValid));

endmodule

bind adc_sequencer adc_seq_checker #(
  .HALF_DIV  (HALF_DIV),
  .POR_CYCLES(POR_CYCLES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .adcCsN      (adcCsN),
  .adcSclk     (adcSclk),
  .adcDout     (adcDout),
  .resultValid (resultValid),
  .gainMismatch(gainMismatch),
  .pollTimeout (pollTimeout)
);

// File: tb/adc_sequencer_bench.sv
module adc_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SYS_HZ     = 12_000_000;
  localparam int MAX_HZ     = 2_000_000;
  localparam int HALF       = 3;
  localparam int POR        = 40;
  localparam int POLLS      = 4;
  localparam int FILL       = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adcCsN, adcSclk, adcDout;
  logic        adcDin;
  logic [23:0] resultData;
  logic        resultValid, gainMismatch, pollTimeout;

  adc_sequencer #(
    .SYS_CLK_HZ     (SYS_HZ),
    .SCLK_MAX_HZ    (MAX_HZ),
    .POR_CYCLES     (POR),
    .POLL_LIMIT     (POLLS),
    .SYNC_FILL_BYTES(FILL)
  ) u_adc_sequencer (
    .clk(clk), .rstN(rstN), .adcCsN(adcCsN), .adcSclk(adcSclk),
    .adcDout(adcDout), .adcDin(adcDin), .resultData(resultData),
    .resultValid(resultValid), .gainMismatch(gainMismatch),
    .pollTimeout(pollTimeout)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // model configuration, set only by the test sequence
  int          calNotDone = 0;
  logic [23:0] gainBack   = 24'h800000;
  bit          convStall  = 1'b0;

  // state owned by the model / monitor process
  logic [7:0]  frm [0:63][0:15];
  int          frmLen [0:63];
  int          nFrm, nRes, convIdx, calLeft, convLeft;
  logic [23:0] resLog [0:15];
  int          negCnt, bitCnt, byteCnt, hiCnt, widthErr, endErr;
  logic [7:0]  curByte;
  logic [23:0] resp;
  logic        inConv, prevCs, prevSclk;

  function automatic logic [23:0] convVal(input int j);
    return 24'hA50000 + 24'(j) * 24'h013579;
  endfunction

  function automatic int sched(input int j, input int k);
    return (j + k) % 3;
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      nFrm = 0; nRes = 0; convIdx = 0; inConv = 1'b0; calLeft = calNotDone;
      convLeft = 0; adcDin = 1'b0; prevCs = 1'b1; prevSclk = 1'b0;
      hiCnt = 0; widthErr = 0; endErr = 0; negCnt = 0; bitCnt = 0; byteCnt = 0;
      curByte = 8'h00; resp = 24'h0;
    end else begin
      if (prevCs && !adcCsN) begin
        negCnt = 0; bitCnt = 0; byteCnt = 0;
      end
      if (!adcCsN && adcSclk && !prevSclk) begin
        curByte = {curByte[6:0], adcDout};
        bitCnt++;
        if (bitCnt == 8) begin
          if (byteCnt < 16 && nFrm < 64) frm[nFrm][byteCnt] = curByte;
          byteCnt++;
          bitCnt = 0;
        end
        hiCnt = 1;
      end else if (adcSclk) begin
        hiCnt++;
      end
      if (!adcSclk && prevSclk) begin
        if (hiCnt != HALF) widthErr++;
        negCnt++;
        if (negCnt == 8 && nFrm < 64) begin
          resp = 24'h0;
          case (frm[nFrm][0])
            8'h94: begin
              if (!inConv) begin
                if (calLeft > 0) begin resp = 24'hFFFFF7; calLeft--; end
                else resp = 24'h000008;
              end else begin
                if (convLeft > 0) begin resp = 24'hFFFFF7; convLeft--; end
                else resp = 24'h000008;
              end
            end
            8'h92: resp = gainBack;
            8'h96: begin resp = convVal(convIdx); convIdx++; end
            8'hC0: begin
              inConv   = 1'b1;
              convLeft = convStall ? 1000 : sched(convIdx, calNotDone);
            end
            default: resp = 24'h0;
          endcase
          adcDin = resp[23];
        end else if (negCnt > 8) begin
          resp   = {resp[22:0], 1'b0};
          adcDin = resp[23];
        end
      end
      if (!prevCs && adcCsN) begin
        if (adcDout) endErr++;
        if (nFrm < 64) begin
          frmLen[nFrm] = byteCnt;
          nFrm++;
        end
        adcDin = 1'b0;
      end
      if (resultValid && nRes < 16) begin
        resLog[nRes] = resultData;
        nRes++;
      end
      prevCs   = adcCsN;
      prevSclk = adcSclk;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  int expIdx;

  task automatic expFrame(input string req, input int len, input logic [31:0] bytes);
    bit ok;
    logic [31:0] got;
    got = 32'h0;
    ok  = (expIdx < nFrm) && (frmLen[expIdx] == len);
    for (int i = 0; i < len; i++) begin
      if (expIdx < nFrm) begin
        got[31 - 8 * i -: 8] = frm[expIdx][i];
        if (frm[expIdx][i] != bytes[31 - 8 * i -: 8]) ok = 1'b0;
      end
    end
    check(ok, req, $sformatf("frame %0d len %0d", expIdx,
          (expIdx < nFrm) ? frmLen[expIdx] : -1), {32'h0, got}, {32'h0, bytes});
    expIdx++;
  endtask

  task automatic checkSync();
    bit ok;
    ok = (nFrm > 0) && (frmLen[0] == FILL + 1);
    for (int i = 0; i <= FILL; i++)
      if (nFrm > 0 && frm[0][i] != ((i == FILL) ? 8'hFE : 8'hFF)) ok = 1'b0;
    // R2: fifteen 0xFF then 0xFE in one frame
    check(ok, "R2", "preamble", 64'(frmLen[0]), 64'(FILL + 1));
    expIdx = 1;
  endtask

  task automatic doReset();
    int cnt;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(adcCsN && !adcSclk && !adcDout && !resultValid && !gainMismatch && !pollTimeout,
          "R1", "reset outputs",
          {58'h0, adcCsN, adcSclk, adcDout, resultValid, gainMismatch, pollTimeout},
          64'h20);
    rstN = 1'b1;
    cnt = 0;
    while (adcCsN && cnt < 4 * POR) begin
      @(negedge clk);
      cnt++;
    end
    // R1: first select fall after the power-on delay
    check(cnt == POR + 1, "R1", "power-on delay", 64'(cnt), 64'(POR + 1));
  endtask

  task automatic waitFor(input int what, input int limit);
    int n;
    n = 0;
    while (n < limit && !((what == 0) ? (nRes >= 3) : pollTimeout)) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic runNormal(input int k, input logic [23:0] gb);
    calNotDone = k; gainBack = gb; convStall = 1'b0;
    doReset();
    waitFor(0, 40000);
    checkSync();
    expFrame("R5", 4, 32'h84000001);
    for (int i = 0; i <= k; i++) expFrame("R6", 4, 32'h94000000);
    expFrame("R7", 4, 32'h82800000);
    expFrame("R7", 4, 32'h92000000);
    for (int j = 0; j < 3; j++) begin
      expFrame("R8", 1, 32'hC0000000);
      for (int p = 0; p <= sched(j, k); p++) expFrame("R6", 4, 32'h94000000);
      expFrame("R8", 4, 32'h96000000);
    end
    for (int j = 0; j < 3; j++)
      check(nRes > j && resLog[j] == convVal(j), "R8", "result word",
            64'(resLog[j]), 64'(convVal(j)));
    // R6: only bit 3 of the poll reply decides; R8 results arrive either way
    check(gainMismatch == (gb != 24'h800000), "R7", "gain mismatch",
          64'(gainMismatch), 64'(gb != 24'h800000));
    check(!pollTimeout, "R9", "no timeout", 64'(pollTimeout), 64'h0);
    check(widthErr == 0, "R4", "clock high width errors", 64'(widthErr), 64'h0);
    check(endErr == 0, "R3", "data low at frame end", 64'(endErr), 64'h0);
  endtask

  task automatic runCalTimeout();
    calNotDone = POLLS; gainBack = 24'h800000; convStall = 1'b0;
    doReset();
    waitFor(1, 40000);
    repeat (600) @(negedge clk);
    checkSync();
    expFrame("R5", 4, 32'h84000001);
    for (int i = 0; i < POLLS; i++) expFrame("R6", 4, 32'h94000000);
    check(nFrm == 2 + POLLS, "R9", "frames after calibration timeout",
          64'(nFrm), 64'(2 + POLLS));
    check(pollTimeout && adcCsN && nRes == 0, "R9", "timeout state",
          {62'h0, pollTimeout, adcCsN}, 64'h3);
  endtask

  task automatic runConvTimeout();
    calNotDone = 0; gainBack = 24'h800000; convStall = 1'b1;
    doReset();
    waitFor(1, 40000);
    repeat (600) @(negedge clk);
    check(nFrm == 6 + POLLS, "R9", "frames after conversion timeout",
          64'(nFrm), 64'(6 + POLLS));
    check(pollTimeout && nRes == 0, "R9", "no result after timeout",
          64'(nRes), 64'h0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    adcDin = 1'b0;
    // R6 sweep: calibration needs k+1 polls, k = 0..3
    for (int k = 0; k < POLLS; k++) runNormal(k, 24'h800000);
    runNormal(1, 24'h800001);
    runNormal(2, 24'h000000);
    runCalTimeout();
    runConvTimeout();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule